// File: doc/BRIEF.md
# Sequential Integer Divide Unit

This block performs the three divide operations of a 16-bit microcontroller datapath, one quotient bit per clock. The caller presents the operation code and the current contents of the Y, D and X registers along with a one-cycle start pulse. Some cycles later the unit raises a one-cycle completion pulse. Alongside it, the unit gives the quotient and remainder, the destination of the quotient, per-destination write enables and the four condition flags N, Z, V and C with their own write enables.

The two extended forms divide the 32-bit value Y:D, with Y as the upper half, by X. One is unsigned and one is two's-complement. The short form divides D by X, both signed. Signed operands are reduced to magnitudes and fed to a single unsigned restoring core, and the signs are applied to the result afterwards. Quotients truncate toward zero and the remainder takes the sign of the dividend. A zero divisor reports C and suppresses every other write. The register file and instruction decode sit outside the block.

Top module: `divr_unit`

## Requirements
- R1: With op = 2'b00 (unsigned extended), the dividend {y_in,d_in} is divided by x_in, all unsigned. The low DATA_W bits of the quotient appear on quo_val with quo_dst_y = 1 (destination Y), and the remainder appears on rem_val (destination D).
- R2: With op = 2'b01 (signed extended), {y_in,d_in} and x_in are two's-complement values. The quotient truncates toward zero, the remainder takes the sign of the dividend, and the routing is the same as in R1.
- R3: With op[1] = 1 (2'b10, and 2'b11 treated the same way), signed d_in is divided by signed x_in and y_in is ignored. The quotient goes to X (quo_dst_y = 0) and the remainder goes to D.
- R4: A zero x_in gives flag_c = 1 with c_we = 1, and quo_we, rem_we and nzv_we stay 0 in the completion cycle.
- R5: A nonzero divisor gives flag_c = 0, and quo_we, rem_we, nzv_we and c_we are all 1. flag_z is 1 exactly when the full-width quotient is zero, and flag_n equals bit DATA_W-1 of quo_val.
- R6: In unsigned extended mode, flag_v = 1 when the quotient is 2**DATA_W or larger. The truncated low bits of the quotient are still written.
- R7: In the signed modes, flag_v = 1 when the quotient lies outside -2**(DATA_W-1) .. 2**(DATA_W-1)-1. In the short form, -32768 / -1 gives flag_v = 1, quo_val = 16'h8000 and flag_n = 1.
- R8: done rises exactly 2*DATA_W+1 cycles after the clock edge that accepts start in the extended modes, and DATA_W+1 cycles after it in the short mode. done lasts one cycle, and every write enable is low outside it.
- R9: A start pulse that arrives while an operation is in flight is ignored. It neither changes the pending result nor produces a second done.
- R10: While reset is asserted and after it is released, done and all write enables are 0. Reset in the middle of an operation cancels it, and no done follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin an operation when idle |
| op | input | 2 | 00 unsigned extended, 01 signed extended, 1x signed short |
| y_in | input | DATA_W | Y register (upper dividend half) |
| d_in | input | DATA_W | D register (lower dividend half or short dividend) |
| x_in | input | DATA_W | X register (divisor) |
| done | output | 1 | One-cycle completion pulse |
| quo_dst_y | output | 1 | Quotient destination: 1 = Y, 0 = X |
| quo_val | output | DATA_W | Quotient value to write |
| rem_val | output | DATA_W | Remainder value for D |
| quo_we | output | 1 | Write quotient destination |
| rem_we | output | 1 | Write D with remainder |
| nzv_we | output | 1 | Update N, Z and V |
| c_we | output | 1 | Update C |
| flag_n | output | 1 | Negative flag value |
| flag_z | output | 1 | Zero flag value |
| flag_v | output | 1 | Overflow flag value |
| flag_c | output | 1 | Divide-by-zero flag value |

## Verification
The bench builds the unit with the default DATA_W = 16 so that its reference arithmetic matches the 16-bit register boundaries. This brings the edge values within reach of directed operands: -32768 / -1 in the short form, a 2**31 magnitude in the signed extended form, and quotients just past 0xFFFF and 0x7FFF. At this width the 33-cycle and 17-cycle latencies keep the busy-window and mid-operation reset scenarios short.

// File: rtl/divr_pkg.sv
package divr_pkg;

  // Operation select codes; bit 1 selects the short signed form.
  typedef enum logic [1:0] {
    DIV_OP_UWIDE  = 2'b00,
    DIV_OP_SWIDE  = 2'b01,
    DIV_OP_SSHORT = 2'b10,
    DIV_OP_SALIAS = 2'b11
  } div_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_FIX  = 2'b10
  } div_state_e;

endpackage

// File: rtl/divr_rst_sync.sv
module divr_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= 2'b00;
    else              sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/divr_operand_prep.sv
// Turns register contents into unsigned magnitudes plus sign bookkeeping.
module divr_operand_prep
  import divr_pkg::*;
#(
  parameter  int DATA_W = 16,
  localparam int WIDE_W = 2 * DATA_W,
  localparam int CNT_W  = $clog2(WIDE_W + 1)
) (
  input  logic [1:0]        op,
  input  logic [DATA_W-1:0] y_in,
  input  logic [DATA_W-1:0] d_in,
  input  logic [DATA_W-1:0] x_in,
  output logic [WIDE_W-1:0] dvd_mag,
  output logic [DATA_W-1:0] dvs_mag,
  output logic [CNT_W-1:0]  iter_cnt,
  output logic              quo_neg,
  output logic              rem_neg,
  output logic              is_signed,
  output logic              is_short,
  output logic              dvs_zero
);

  logic [WIDE_W-1:0] wide_raw;
  logic [WIDE_W-1:0] wide_abs;
  logic [DATA_W-1:0] short_abs;
  logic              dvd_neg;
  logic              dvs_neg;

  always_comb begin
    is_short  = op[1];
    is_signed = (op != DIV_OP_UWIDE);
    wide_raw  = {y_in, d_in};
    // R2/R3: dividend sign comes from the top bit of the active dividend.
    dvd_neg   = is_signed & (is_short ? d_in[DATA_W-1] : y_in[DATA_W-1]);
    dvs_neg   = is_signed & x_in[DATA_W-1];
    wide_abs  = dvd_neg ? -wide_raw : wide_raw;
    short_abs = dvd_neg ? -d_in : d_in;
    // Short form: dividend sits in the upper half so DATA_W shifts finish it.
    dvd_mag   = is_short ? {short_abs, {DATA_W{1'b0}}} : wide_abs;
    dvs_mag   = dvs_neg ? -x_in : x_in;
    quo_neg   = dvd_neg ^ dvs_neg;
    rem_neg   = dvd_neg;
    iter_cnt  = is_short ? CNT_W'(DATA_W) : CNT_W'(WIDE_W);
    dvs_zero  = (x_in == '0);
  end

endmodule

// File: rtl/divr_iter_core.sv
// Unsigned restoring divider, one quotient bit per enabled cycle.
module divr_iter_core #(
  parameter  int DATA_W = 16,
  localparam int WIDE_W = 2 * DATA_W,
  localparam int CNT_W  = $clog2(WIDE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WIDE_W-1:0] dvd_in,
  input  logic [DATA_W-1:0] dvs_in,
  input  logic [CNT_W-1:0]  cnt_in,
  output logic [WIDE_W-1:0] quo_mag,
  output logic [DATA_W-1:0] rem_mag,
  output logic              last
);

  logic [WIDE_W-1:0] acc_q, acc_d;
  logic [DATA_W-1:0] rem_q, rem_d;
  logic [DATA_W-1:0] dvs_q, dvs_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              core_ce;

  logic [DATA_W:0]   part;
  logic [DATA_W:0]   dvs_ext;
  logic [DATA_W:0]   diff;
  logic              fits;

  always_comb begin
    part    = {rem_q, acc_q[WIDE_W-1]};
    dvs_ext = {1'b0, dvs_q};
    fits    = (part >= dvs_ext);
    diff    = part - dvs_ext;
    core_ce = load | (cnt_q != '0);
    if (load) begin
      acc_d = dvd_in;
      rem_d = '0;
      dvs_d = dvs_in;
      cnt_d = cnt_in;
    end else begin
      acc_d = {acc_q[WIDE_W-2:0], fits};
      rem_d = fits ? diff[DATA_W-1:0] : part[DATA_W-1:0];
      dvs_d = dvs_q;
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      rem_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
    end else if (core_ce) begin
      acc_q <= acc_d;
      rem_q <= rem_d;
      dvs_q <= dvs_d;
      cnt_q <= cnt_d;
    end
  end

  assign quo_mag = acc_q;
  assign rem_mag = rem_q;
  assign last    = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/divr_result_fix.sv
// Applies signs to the magnitudes and derives the condition flags.
module divr_result_fix #(
  parameter  int DATA_W = 16,
  localparam int WIDE_W = 2 * DATA_W
) (
  input  logic [WIDE_W-1:0] quo_mag,
  input  logic [DATA_W-1:0] rem_mag,
  input  logic              quo_neg,
  input  logic              rem_neg,
  input  logic              is_signed,
  input  logic              dvs_zero,
  output logic [DATA_W-1:0] quo_val,
  output logic [DATA_W-1:0] rem_val,
  output logic              n_flag,
  output logic              z_flag,
  output logic              v_flag,
  output logic              c_flag
);

  localparam logic [WIDE_W-1:0] HALF_LIM =
    {{(WIDE_W - DATA_W){1'b0}}, 1'b1, {(DATA_W - 1){1'b0}}};

  logic [WIDE_W-1:0] q_full;
  logic              hi_nz;

  always_comb begin
    q_full  = quo_neg ? -quo_mag : quo_mag;
    quo_val = q_full[DATA_W-1:0];
    rem_val = rem_neg ? -rem_mag : rem_mag;
    hi_nz   = |quo_mag[WIDE_W-1:DATA_W];
    z_flag  = (quo_mag == '0);                 // R5: full-width zero test
    n_flag  = q_full[DATA_W-1];                // R5
    if (!is_signed) v_flag = hi_nz;            // R6
    else if (quo_neg) v_flag = (quo_mag > HALF_LIM);   // R7
    else v_flag = (quo_mag >= HALF_LIM);               // R7
    c_flag  = dvs_zero;                        // R4
  end

endmodule

// File: rtl/divr_unit.sv
module divr_unit
  import divr_pkg::*;
#(
  parameter  int DATA_W = 16,
  localparam int WIDE_W = 2 * DATA_W,
  localparam int CNT_W  = $clog2(WIDE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        op,
  input  logic [DATA_W-1:0] y_in,
  input  logic [DATA_W-1:0] d_in,
  input  logic [DATA_W-1:0] x_in,
  output logic              done,
  output logic              quo_dst_y,
  output logic [DATA_W-1:0] quo_val,
  output logic [DATA_W-1:0] rem_val,
  output logic              quo_we,
  output logic              rem_we,
  output logic              nzv_we,
  output logic              c_we,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_v,
  output logic              flag_c
);

  logic rst_sync_n;

  divr_rst_sync u_rst_sync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_sync_n)
  );

  // Operand preparation
  logic [WIDE_W-1:0] prep_dvd;
  logic [DATA_W-1:0] prep_dvs;
  logic [CNT_W-1:0]  prep_cnt;
  logic              prep_qneg, prep_rneg, prep_signed, prep_short, prep_zero;

  divr_operand_prep #(.DATA_W(DATA_W)) u_prep (
    .op        (op),
    .y_in      (y_in),
    .d_in      (d_in),
    .x_in      (x_in),
    .dvd_mag   (prep_dvd),
    .dvs_mag   (prep_dvs),
    .iter_cnt  (prep_cnt),
    .quo_neg   (prep_qneg),
    .rem_neg   (prep_rneg),
    .is_signed (prep_signed),
    .is_short  (prep_short),
    .dvs_zero  (prep_zero)
  );

  // Control
  div_state_e state_q, state_d;
  logic       accept;
  logic       fix_now;
  logic       core_last;
  logic       unit_idle;

  assign unit_idle = (state_q == ST_IDLE);
  assign accept    = start & unit_idle;       // R9: start ignored unless idle
  assign fix_now   = (state_q == ST_FIX);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_RUN;
      ST_RUN:  if (core_last) state_d = ST_FIX;
      ST_FIX:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= ST_IDLE;
    else             state_q <= state_d;
  end

  // Per-operation context, captured on accept
  logic qneg_q, rneg_q, signed_q, short_q, zero_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      qneg_q   <= 1'b0;
      rneg_q   <= 1'b0;
      signed_q <= 1'b0;
      short_q  <= 1'b0;
      zero_q   <= 1'b0;
    end else if (accept) begin
      qneg_q   <= prep_qneg;
      rneg_q   <= prep_rneg;
      signed_q <= prep_signed;
      short_q  <= prep_short;
      zero_q   <= prep_zero;
    end
  end

  // Iteration core
  logic [WIDE_W-1:0] core_quo;
  logic [DATA_W-1:0] core_rem;

  divr_iter_core #(.DATA_W(DATA_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (accept),
    .dvd_in  (prep_dvd),
    .dvs_in  (prep_dvs),
    .cnt_in  (prep_cnt),
    .quo_mag (core_quo),
    .rem_mag (core_rem),
    .last    (core_last)
  );

  // Sign correction and flags
  logic [DATA_W-1:0] fix_quo, fix_rem;
  logic              fix_n, fix_z, fix_v, fix_c;

  divr_result_fix #(.DATA_W(DATA_W)) u_fix (
    .quo_mag   (core_quo),
    .rem_mag   (core_rem),
    .quo_neg   (qneg_q),
    .rem_neg   (rneg_q),
    .is_signed (signed_q),
    .dvs_zero  (zero_q),
    .quo_val   (fix_quo),
    .rem_val   (fix_rem),
    .n_flag    (fix_n),
    .z_flag    (fix_z),
    .v_flag    (fix_v),
    .c_flag    (fix_c)
  );

  // Result registers, loaded in the fix-up cycle
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      quo_val   <= '0;
      rem_val   <= '0;
      quo_dst_y <= 1'b0;
      flag_n    <= 1'b0;
      flag_z    <= 1'b0;
      flag_v    <= 1'b0;
      flag_c    <= 1'b0;
    end else if (fix_now) begin
      quo_val   <= fix_quo;
      rem_val   <= fix_rem;
      quo_dst_y <= ~short_q;                  // R1/R3 routing
      flag_n    <= fix_n;
      flag_z    <= fix_z;
      flag_v    <= fix_v;
      flag_c    <= fix_c;
    end
  end

  // Strobes, one cycle wide (R4, R5, R8, R10)
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      done   <= 1'b0;
      quo_we <= 1'b0;
      rem_we <= 1'b0;
      nzv_we <= 1'b0;
      c_we   <= 1'b0;
    end else begin
      done   <= fix_now;
      quo_we <= fix_now & ~zero_q;
      rem_we <= fix_now & ~zero_q;
      nzv_we <= fix_now & ~zero_q;
      c_we   <= fix_now;
    end
  end

endmodule

// File: rtl/divr_unit_chk.sv
module divr_unit_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              unit_idle,
  input logic [1:0]        op,
  input logic              done,
  input logic              quo_dst_y,
  input logic [DATA_W-1:0] quo_val,
  input logic              quo_we,
  input logic              rem_we,
  input logic              nzv_we,
  input logic              c_we,
  input logic              flag_n,
  input logic              flag_z,
  input logic              flag_v,
  input logic              flag_c
);

  localparam int LAT_W = $clog2(2 * DATA_W + 3);

  logic [LAT_W-1:0] wait_q;
  logic             short_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q  <= '0;
      short_q <= 1'b0;
    end else if (start && unit_idle) begin
      wait_q  <= op[1] ? LAT_W'(DATA_W + 1) : LAT_W'(2 * DATA_W + 1);
      short_q <= op[1];
    end else if (wait_q != '0) begin
      wait_q  <= wait_q - LAT_W'(1);
    end
  end

  assert_done_on_time_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_q == LAT_W'(1)) |=> done);

  assert_no_stray_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(wait_q) == LAT_W'(1)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_we_in_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (quo_we || rem_we || nzv_we || c_we) |-> done);

  assert_zero_div_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && flag_c) |-> (c_we && !quo_we && !rem_we && !nzv_we));

  assert_writes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !flag_c) |-> (c_we && quo_we && rem_we && nzv_we));

  assert_neg_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && nzv_we) |-> (flag_n == quo_val[DATA_W-1]));

  assert_zero_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && nzv_we && flag_z) |-> (quo_val == '0));

  assert_route_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && quo_we) |-> (quo_dst_y == !short_q));

  assert_short_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && nzv_we && flag_v && !quo_dst_y) |->
      (quo_val == {1'b1, {(DATA_W - 1){1'b0}}}));

endmodule

bind divr_unit divr_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .start     (start),
  .unit_idle (unit_idle),
  .op        (op),
  .done      (done),
  .quo_dst_y (quo_dst_y),
  .quo_val   (quo_val),
  .quo_we    (quo_we),
  .rem_we    (rem_we),
  .nzv_we    (nzv_we),
  .c_we      (c_we),
  .flag_n    (flag_n),
  .flag_z    (flag_z),
  .flag_v    (flag_v),
  .flag_c    (flag_c)
);

// File: tb/divr_unit_tb.sv
module divr_unit_tb;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [1:0]   op;
  logic [W-1:0] y_in, d_in, x_in;
  logic         done, quo_dst_y, quo_we, rem_we, nzv_we, c_we;
  logic         flag_n, flag_z, flag_v, flag_c;
  logic [W-1:0] quo_val, rem_val;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #5 clk = ~clk;

  divr_unit #(.DATA_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .y_in(y_in), .d_in(d_in), .x_in(x_in),
    .done(done), .quo_dst_y(quo_dst_y), .quo_val(quo_val), .rem_val(rem_val),
    .quo_we(quo_we), .rem_we(rem_we), .nzv_we(nzv_we), .c_we(c_we),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
  );

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not finish, actual=%0d expected<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    start = 1'b0;
    op    = 2'b00;
    y_in  = '0;
    d_in  = '0;
    x_in  = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Issue one operation, wait for done, compare against reference arithmetic.
  task automatic run_div(input string req, input logic [1:0] opc,
                         input logic [W-1:0] y, input logic [W-1:0] d,
                         input logic [W-1:0] x);
    longint dvd, dvs, q, r;
    bit     wide, sgn, zero, ev;
    int     k;
    wide = !opc[1];
    sgn  = (opc != 2'b00);
    if (!sgn) begin
      dvd = longint'({y, d});
      dvs = longint'(x);
    end else if (wide) begin
      dvd = longint'($signed({y, d}));
      dvs = longint'($signed(x));
    end else begin
      dvd = longint'($signed(d));
      dvs = longint'($signed(x));
    end
    zero = (dvs == 0);
    q = 0; r = 0; ev = 0;
    if (!zero) begin
      q  = dvd / dvs;
      r  = dvd % dvs;
      ev = !sgn ? (q > 65535) : ((q > 32767) || (q < -32768));
    end
    @(negedge clk);
    op = opc; y_in = y; d_in = d; x_in = x; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    y_in = 16'h5A5A; d_in = 16'hA5A5; x_in = 16'h0003;
    k = 0;
    while (!done && k < 200) begin
      @(negedge clk);
      k++;
    end
    chk("R8", "latency", k, wide ? 2 * W + 1 : W + 1);
    chk("R4", "c_we", c_we, 1);
    chk(zero ? "R4" : "R5", "flag_c", flag_c, zero);
    if (zero) begin
      chk("R4", "quo_we", quo_we, 0);
      chk("R4", "rem_we", rem_we, 0);
      chk("R4", "nzv_we", nzv_we, 0);
    end else begin
      chk("R5", "quo_we", quo_we, 1);
      chk("R5", "rem_we", rem_we, 1);
      chk("R5", "nzv_we", nzv_we, 1);
      chk(wide ? "R1" : "R3", "quo_dst_y", quo_dst_y, wide);
      chk(req, "quotient", quo_val, longint'(q[W-1:0]));
      chk(req, "remainder", rem_val, longint'(r[W-1:0]));
      chk("R5", "flag_z", flag_z, (q == 0));
      chk("R5", "flag_n", flag_n, q[W-1]);
      chk(sgn ? "R7" : "R6", "flag_v", flag_v, ev);
    end
    @(negedge clk);
    chk("R8", "done one cycle", done, 0);
    chk("R8", "enables low after done", quo_we | rem_we | nzv_we | c_we, 0);
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    start = 1'b0;
    op = 2'b00; y_in = '0; d_in = '0; x_in = '0;
    repeat (3) @(negedge clk);
    chk("R10", "done in reset", done, 0);
    chk("R10", "enables in reset", quo_we | rem_we | nzv_we | c_we, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10", "done after release", done, 0);
  endtask

  task automatic t_unsigned_wide();
    run_div("R1", 2'b00, 16'h0001, 16'h0000, 16'h0002);
    run_div("R1", 2'b00, 16'h1234, 16'h5678, 16'hABCD);
    run_div("R1", 2'b00, 16'h0000, 16'h0005, 16'h0009);
    run_div("R1", 2'b00, 16'hFFFE, 16'hFFFF, 16'hFFFF);
    run_div("R6", 2'b00, 16'h0002, 16'h0000, 16'h0001);
    run_div("R6", 2'b00, 16'h0001, 16'h0000, 16'h0001);
  endtask

  task automatic t_signed_wide();
    run_div("R2", 2'b01, 16'hFFFF, 16'hFF9C, 16'h0007);
    run_div("R2", 2'b01, 16'hFFFF, 16'hFF9C, 16'hFFF9);
    run_div("R2", 2'b01, 16'h0000, 16'h0064, 16'hFFF9);
    run_div("R2", 2'b01, 16'hFFFF, 16'h8000, 16'h0001);
    run_div("R7", 2'b01, 16'h0000, 16'h8000, 16'h0001);
    run_div("R7", 2'b01, 16'h8000, 16'h0000, 16'hFFFF);
    run_div("R7", 2'b01, 16'h0001, 16'h0000, 16'h0001);
  endtask

  task automatic t_signed_short();
    run_div("R3", 2'b10, 16'hDEAD, 16'h0064, 16'h0007);
    run_div("R3", 2'b10, 16'hBEEF, 16'hFF9C, 16'h0007);
    run_div("R3", 2'b11, 16'h1234, 16'h0064, 16'hFFF9);
    run_div("R3", 2'b10, 16'h0000, 16'h0003, 16'h0008);
    run_div("R7", 2'b10, 16'h0000, 16'h8000, 16'hFFFF);
  endtask

  task automatic t_zero_divisor();
    run_div("R4", 2'b00, 16'h1234, 16'h5678, 16'h0000);
    run_div("R4", 2'b01, 16'hFFFF, 16'hFFFF, 16'h0000);
    run_div("R4", 2'b10, 16'h0000, 16'h0042, 16'h0000);
  endtask

  task automatic t_busy_start();
    int k;
    int extra;
    @(negedge clk);
    op = 2'b10; y_in = 16'h0000; d_in = 16'd100; x_in = 16'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0;
    repeat (3) begin @(negedge clk); k++; end
    op = 2'b00; y_in = 16'h0003; d_in = 16'h0000; x_in = 16'h0000; start = 1'b1;
    @(negedge clk); k++;
    start = 1'b0;
    while (!done && k < 200) begin
      @(negedge clk);
      k++;
    end
    chk("R9", "latency with busy start", k, W + 1);
    chk("R9", "quotient kept", quo_val, 14);
    chk("R9", "remainder kept", rem_val, 2);
    chk("R9", "flag_c kept", flag_c, 0);
    extra = 0;
    for (int i = 0; i < 2 * W + 6; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk("R9", "no second done", extra, 0);
  endtask

  task automatic t_reset_mid();
    int seen;
    @(negedge clk);
    op = 2'b01; y_in = 16'h0000; d_in = 16'h1000; x_in = 16'h0010; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10", "done during reset", done, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    seen = 0;
    for (int i = 0; i < 2 * W + 8; i++) begin
      @(negedge clk);
      if (done || quo_we || c_we) seen++;
    end
    chk("R10", "no done after mid-op reset", seen, 0);
  endtask

  initial begin
    t_reset_state();
    do_reset();
    t_unsigned_wide();
    t_signed_wide();
    t_signed_short();
    t_zero_divisor();
    t_busy_start();
    t_reset_mid();
    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule